// File: doc/BRIEF.md
# Eight-bit Integer and Fractional Multiply Unit

This unit executes the multiply instructions of a small 8-bit processor core. Each cycle it may receive one 16-bit instruction word. It recognises six multiply variants from the bit pattern: unsigned, signed, and signed-by-unsigned, each with and without a fractional one-bit left shift of the result. It works out which two general registers hold the operands and drives those two indices to the core's 32-entry register file. The file answers combinationally.

One clock later the unit returns the 16-bit product, meant for the fixed register pair R1 (high byte) and R0 (low byte), together with an updated status byte. Only the zero and carry bits of the status byte change; the other six bits pass through from the status byte supplied with the instruction. An instruction word that is not a multiply, or a cycle with no valid instruction, produces no result. In that case the result and status outputs keep their last values.

Top module: `mul8_unit`

## Requirements
- R1: While reset is high, and on the first output cycle after it, `res_valid` is 0, `res_prod` is 0 and `flags_out` is 0.
- R2: Word pattern `100111 r4 d4 dddd rrrr` is unsigned times unsigned. The first operand index is {bit 8, bits 7:4}, so any of the 32 registers can be chosen. The second operand index is {bit 9, bits 3:0}. The product is the full 16-bit unsigned product.
- R3: High byte 0x02 is signed times signed. The first operand index is 16 + bits 7:4 and the second is 16 + bits 3:0. Both operands are two's complement.
- R4: High byte 0x03 with bit 7 = 0 and bit 3 = 0 is the mixed multiply. The first operand index is 16 + bits 6:4 and is signed. The second operand index is 16 + bits 2:0 and is unsigned.
- R5: High byte 0x03 selects a fractional multiply when {bit 7, bit 3} is 01, 10 or 11. These are unsigned × unsigned, signed × signed and signed × unsigned respectively. They use the same indices as R4, and the 16-bit product is shifted left by one before it is output.
- R6: Status bit 0 (carry) equals bit 15 of the product before any fractional shift.
- R7: Status bit 1 (zero) is 1 exactly when the 16-bit output result is zero.
- R8: Status bits 7:2 of `flags_out` equal bits 7:2 of the `flags_in` that came with the instruction.
- R9: A valid multiply instruction gives `res_valid` = 1, with product and status, exactly one clock after it is presented.
- R10: When `op_valid` is low or the word is not a multiply, `res_valid` is 0 on the next cycle, and `res_prod` and `flags_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An instruction word is present this cycle |
| opcode | input | 16 | Instruction word |
| flags_in | input | 8 | Current status byte (bit 0 carry, bit 1 zero) |
| dst_sel | output | 5 | Register index of the first operand |
| src_sel | output | 5 | Register index of the second operand |
| dst_val | input | 8 | Register file data at `dst_sel`, same cycle |
| src_val | input | 8 | Register file data at `src_sel`, same cycle |
| res_valid | output | 1 | Product is valid, to be written to R1:R0 |
| res_prod | output | 16 | Product, high byte for R1, low byte for R0 |
| flags_out | output | 8 | Updated status byte |

## Verification
Register indices are combinational in the cycle the instruction word is applied. Every result, zero and carry bit and status pass-through bit is due at the first rising edge after that. The bench drives each instruction at a falling edge and computes the expected outcome from its own integer arithmetic at the same moment. It compares the outputs at the next falling edge, half a period after the registering edge and before the next instruction is driven. The same comparison covers non-multiply words and idle cycles: one cycle after them the bench expects no result and unchanged outputs.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
    localparam int REG_W   = 8;
    localparam int REG_CNT = 32;
    localparam int IDX_W   = $clog2(REG_CNT);
    localparam int PROD_W  = 2 * REG_W;
    localparam int OP_W    = 16;
    localparam int FLAG_W  = 8;
    localparam int CF_POS  = 0;
    localparam int ZF_POS  = 1;

    typedef enum logic [2:0] {
        MD_NONE,
        MD_UU,
        MD_SS,
        MD_SU,
        MD_FUU,
        MD_FSS,
        MD_FSU
    } mul_mode_e;

    typedef struct packed {
        logic             legal;
        mul_mode_e        mode;
        logic [IDX_W-1:0] d_idx;
        logic [IDX_W-1:0] s_idx;
    } mul_ctl_t;

    typedef struct packed {
        logic [PROD_W-1:0] value;
        logic              zf;
        logic              cf;
    } mul_res_t;

    function automatic logic mode_d_signed(mul_mode_e m);
        return (m == MD_SS) || (m == MD_SU) || (m == MD_FSS) || (m == MD_FSU);
    endfunction

    function automatic logic mode_s_signed(mul_mode_e m);
        return (m == MD_SS) || (m == MD_FSS);
    endfunction

    function automatic logic mode_frac(mul_mode_e m);
        return (m == MD_FUU) || (m == MD_FSS) || (m == MD_FSU);
    endfunction
endpackage

// File: rtl/mul8_decode.sv
module mul8_decode
    import mul8_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output mul_ctl_t        ctl
);
    always_comb begin
        ctl       = '0;
        ctl.mode  = MD_NONE;
        if (opcode[15:10] == 6'b100111) begin
            ctl.legal = 1'b1;
            ctl.mode  = MD_UU;
            ctl.d_idx = {opcode[8], opcode[7:4]};
            ctl.s_idx = {opcode[9], opcode[3:0]};
        end else if (opcode[15:8] == 8'h02) begin
            ctl.legal = 1'b1;
            ctl.mode  = MD_SS;
            ctl.d_idx = {1'b1, opcode[7:4]};
            ctl.s_idx = {1'b1, opcode[3:0]};
        end else if (opcode[15:8] == 8'h03) begin
            ctl.legal = 1'b1;
            ctl.d_idx = {2'b10, opcode[6:4]};
            ctl.s_idx = {2'b10, opcode[2:0]};
            case ({opcode[7], opcode[3]})
                2'b00:   ctl.mode = MD_SU;
                2'b01:   ctl.mode = MD_FUU;
                2'b10:   ctl.mode = MD_FSS;
                default: ctl.mode = MD_FSU;
            endcase
        end
    end
endmodule

// File: rtl/mul8_core.sv
module mul8_core
    import mul8_pkg::*;
(
    input  logic [REG_W-1:0] d_val,
    input  logic [REG_W-1:0] s_val,
    input  mul_mode_e        mode,
    output mul_res_t         res
);
    localparam int EXT_W  = REG_W + 1;
    localparam int FULL_W = 2 * EXT_W;

    logic signed [EXT_W-1:0]  d_ext;
    logic signed [EXT_W-1:0]  s_ext;
    logic signed [FULL_W-1:0] full;
    logic [PROD_W-1:0]        raw;

    always_comb begin
        d_ext = {mode_d_signed(mode) & d_val[REG_W-1], d_val};
        s_ext = {mode_s_signed(mode) & s_val[REG_W-1], s_val};
        full  = d_ext * s_ext;
        raw   = full[PROD_W-1:0];
        res.cf    = raw[PROD_W-1];
        res.value = mode_frac(mode) ? {raw[PROD_W-2:0], 1'b0} : raw;
        res.zf    = (res.value == '0);
    end
endmodule

// File: rtl/mul8_unit.sv
module mul8_unit
    import mul8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [IDX_W-1:0]  dst_sel,
    output logic [IDX_W-1:0]  src_sel,
    input  logic [REG_W-1:0]  dst_val,
    input  logic [REG_W-1:0]  src_val,
    output logic              res_valid,
    output logic [PROD_W-1:0] res_prod,
    output logic [FLAG_W-1:0] flags_out
);
    mul_ctl_t          ctl;
    mul_res_t          res;
    logic [FLAG_W-1:0] flags_nx;

    mul8_decode u_decode (
        .opcode (opcode),
        .ctl    (ctl)
    );

    assign dst_sel = ctl.d_idx;
    assign src_sel = ctl.s_idx;

    mul8_core u_core (
        .d_val (dst_val),
        .s_val (src_val),
        .mode  (ctl.mode),
        .res   (res)
    );

    always_comb begin
        flags_nx         = flags_in;
        flags_nx[CF_POS] = res.cf;
        flags_nx[ZF_POS] = res.zf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_prod  <= '0;
            flags_out <= '0;
        end else if (op_valid && ctl.legal) begin
            res_valid <= 1'b1;
            res_prod  <= res.value;
            flags_out <= flags_nx;
        end else begin
            res_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk
    import mul8_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [OP_W-1:0]   opcode,
    input logic [FLAG_W-1:0] flags_in,
    input logic [IDX_W-1:0]  dst_sel,
    input logic [IDX_W-1:0]  src_sel,
    input logic              res_valid,
    input logic [PROD_W-1:0] res_prod,
    input logic [FLAG_W-1:0] flags_out
);
    // R1: reset clears the output stage
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!res_valid && res_prod == '0 && flags_out == '0));

    // R3: signed mode reads the upper half of the file
    a_r3_upper_half: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode[15:8] == 8'h02) |-> (dst_sel[4] && src_sel[4]));

    // R4, R5: mixed and fractional modes stay inside registers 16..23
    a_r4_narrow_window: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode[15:8] == 8'h03) |-> (dst_sel[4:3] == 2'b10 && src_sel[4:3] == 2'b10));

    // R7: zero bit agrees with the delivered product
    a_r7_zero_match: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (flags_out[ZF_POS] == (res_prod == '0)));

    // R8: untouched status bits follow the input of the previous cycle
    a_r8_pass_bits: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (flags_out[FLAG_W-1:2] == $past(flags_in[FLAG_W-1:2])));

    // R9: a valid word with high byte 0x02 or 0x03 yields a result next cycle
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode[15:9] == 7'b0000001) |=> res_valid);

    // R10: idle cycles and words with high byte 0x00/0x01 produce nothing
    a_r10_no_result: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || opcode[15:9] == 7'b0000000) |=> !res_valid);

    // R10: outputs hold when no result is delivered
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(res_prod) && $stable(flags_out)));
endmodule

bind mul8_unit mul8_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .flags_in  (flags_in),
    .dst_sel   (dst_sel),
    .src_sel   (src_sel),
    .res_valid (res_valid),
    .res_prod  (res_prod),
    .flags_out (flags_out)
);

// File: tb/mul8_unit_bench.sv
module mul8_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic [7:0]  flags_in = '0;
    logic [4:0]  dst_sel, src_sel;
    logic [7:0]  dst_val, src_val;
    logic        res_valid;
    logic [15:0] res_prod;
    logic [7:0]  flags_out;

    logic [7:0] regs [32];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model of the output stage
    logic        exp_valid = 1'b0;
    logic [15:0] exp_prod = '0;
    logic [7:0]  exp_flags = '0;
    string       exp_tag = "R1";

    always #(CLK_P/2) clk = ~clk;

    assign dst_val = regs[dst_sel];
    assign src_val = regs[src_sel];

    mul8_unit u_mul8_unit (
        .clk (clk), .rst (rst), .op_valid (op_valid), .opcode (opcode),
        .flags_in (flags_in), .dst_sel (dst_sel), .src_sel (src_sel),
        .dst_val (dst_val), .src_val (src_val), .res_valid (res_valid),
        .res_prod (res_prod), .flags_out (flags_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check(exp_valid ? "R9" : "R10", {31'd0, res_valid}, {31'd0, exp_valid}, "res_valid");
        check(exp_valid ? exp_tag : "R10", {16'd0, res_prod}, {16'd0, exp_prod}, "res_prod");
        check(exp_valid ? "R6" : "R10", {31'd0, flags_out[0]}, {31'd0, exp_flags[0]}, "carry");
        check(exp_valid ? "R7" : "R10", {31'd0, flags_out[1]}, {31'd0, exp_flags[1]}, "zero");
        check(exp_valid ? "R8" : "R10", {26'd0, flags_out[7:2]}, {26'd0, exp_flags[7:2]}, "upper status");
    endtask

    task automatic scramble();
        for (int i = 0; i < 32; i++) regs[i] = 8'($urandom);
        flags_in = 8'($urandom);
    endtask

    // m: 0 uu, 1 ss, 2 su, 3 frac uu, 4 frac ss, 5 frac su
    task automatic drive_mul(int m, logic [7:0] a, logic [7:0] b);
        logic [4:0]  d, s;
        logic [7:0]  av, bv;
        int          ai, bi, p;
        logic [31:0] pv;
        @(negedge clk);
        compare();
        scramble();
        case (m)
            0:       begin d = 5'($urandom % 32); s = 5'($urandom % 32); end
            1:       begin d = 5'(16 + $urandom % 16); s = 5'(16 + $urandom % 16); end
            default: begin d = 5'(16 + $urandom % 8); s = 5'(16 + $urandom % 8); end
        endcase
        regs[d] = a;
        regs[s] = b;
        case (m)
            0: opcode = {6'b100111, s[4], d[4], d[3:0], s[3:0]};
            1: opcode = {8'h02, d[3:0], s[3:0]};
            2: opcode = {8'h03, 1'b0, d[2:0], 1'b0, s[2:0]};
            3: opcode = {8'h03, 1'b0, d[2:0], 1'b1, s[2:0]};
            4: opcode = {8'h03, 1'b1, d[2:0], 1'b0, s[2:0]};
            default: opcode = {8'h03, 1'b1, d[2:0], 1'b1, s[2:0]};
        endcase
        op_valid = 1'b1;
        av = regs[d];
        bv = regs[s];
        ai = int'(av);
        bi = int'(bv);
        if ((m == 1 || m == 2 || m == 4 || m == 5) && av >= 8'd128) ai = ai - 256;
        if ((m == 1 || m == 4) && bv >= 8'd128) bi = bi - 256;
        p  = ai * bi;
        pv = 32'(p);
        exp_valid = 1'b1;
        exp_prod  = (m >= 3) ? {pv[14:0], 1'b0} : pv[15:0];
        exp_flags = {flags_in[7:2], exp_prod == 16'd0, pv[15]};
        case (m)
            0:       exp_tag = "R2";
            1:       exp_tag = "R3";
            2:       exp_tag = "R4";
            default: exp_tag = "R5";
        endcase
    endtask

    task automatic drive_other(logic [15:0] op, logic v);
        @(negedge clk);
        compare();
        scramble();
        opcode    = op;
        op_valid  = v;
        exp_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] corners [16];
        corners = '{8'h00, 8'h01, 8'h02, 8'h7f, 8'h80, 8'h81, 8'hff, 8'hfe,
                    8'h40, 8'h55, 8'haa, 8'hc0, 8'h3f, 8'h10, 8'h0f, 8'h99};
        for (int i = 0; i < 32; i++) regs[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        check("R1", {31'd0, res_valid}, 32'd0, "reset valid");
        check("R1", {16'd0, res_prod}, 32'd0, "reset product");
        check("R1", {24'd0, flags_out}, 32'd0, "reset status");
        rst = 1'b0;
        // directed corners, R6 and R7 edge values
        drive_mul(1, 8'h80, 8'h80);   // +16384, carry 0
        drive_mul(4, 8'h80, 8'h80);   // frac: 0x8000, carry 0
        drive_mul(0, 8'hff, 8'hff);   // 0xfe01, carry 1
        drive_mul(3, 8'h80, 8'h00);   // zero
        drive_mul(5, 8'hff, 8'h01);   // -1 -> 0xfffe
        drive_mul(2, 8'h80, 8'hff);   // -32640
        // R10: illegal words and idle cycles
        drive_other(16'h0100, 1'b1);
        drive_other(16'h9800, 1'b1);
        drive_other(16'h0211, 1'b0);
        drive_other(16'h0455, 1'b1);
        // sweep every mode: full first operand range against corner set
        for (int m = 0; m < 6; m++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    drive_mul(m, 8'(a), corners[(k + a) % 16]);
        // random mix with idle and illegal cycles
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom % 10);
            if (r == 0)      drive_other(16'(($urandom % 2) ? 16'h0000 : 16'h9a00) | 16'($urandom % 256), 1'b1);
            else if (r == 1) drive_other({6'b100111, 10'($urandom)}, 1'b0);
            else             drive_mul(int'($urandom % 6), 8'($urandom), 8'($urandom));
        end
        drive_other(16'h0000, 1'b0);
        @(negedge clk);
        compare();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule